// File: doc/BRIEF.md
# Scalar ALU with Condition Flag

This block executes one instruction from a 32-bit two-source scalar format. The instruction word, together with two operand values already read from an external register file, arrives on a valid/ready input. The block decodes the opcode and computes a 32-bit result. It also keeps a one-bit condition flag that persists from one instruction to the next.

That single flag does several jobs, depending on the operation:

- carry-out for an add
- borrow for a subtract
- signed-overflow indicator for a signed add or subtract
- "first operand chosen" marker for a minimum

The flag also feeds back as the carry-in or borrow-in of the chained add and subtract, so multi-word arithmetic can be built from a sequence of instructions.

Each accepted instruction produces one output beat one cycle later. The beat carries the result, the destination register index, a write-enable and an illegal-encoding indication. The output uses the following back-pressure rules:

- A transfer happens on a rising clock edge where the valid and ready of an interface are both high.
- The input is ready whenever the output register is empty or is being drained in the same cycle.
- While the output is valid and not accepted, every output field is held unchanged and no new instruction is taken.

Top module: `scalar_alu_flag`

## Requirements
- R1: The instruction word is split as follows: bits 7:0 first source select, bits 15:8 second source select, bits 22:16 destination index, bits 29:23 opcode, bits 31:30 format tag. The destination index of an accepted instruction appears on res_dst one cycle after the transfer.
- R2: Opcode 0 (unsigned add) writes the low 32 bits of src0 + src1 and sets the flag to the carry out of bit 31.
- R3: Opcode 1 (unsigned subtract) writes src0 − src1 modulo 2^32 and sets the flag to 1 exactly when src0 < src1 unsigned (a borrow).
- R4: Opcodes 2 (signed add) and 3 (signed subtract) write the wrapped 32-bit result. They set the flag to 1 exactly when the two's-complement result overflows.
- R5: Opcode 4 (add with carry) forms src0 + src1 + flag in 33 bits, writes the low 32 bits and sets the flag to bit 32.
- R6: Opcode 5 (subtract with borrow) forms src0 − src1 − flag, writes the low 32 bits and sets the flag to the borrow out of the 32-bit subtraction.
- R7: Opcodes 6 (signed minimum) and 7 (unsigned minimum) write the smaller source under the matching comparison. The flag is set to 1 exactly when src0 < src1 strictly, in which case src0 is written. Otherwise the flag is 0 and src1 is written.
- R8: An instruction whose format tag is not binary 10, or whose opcode exceeds 7, is flagged illegal: res_illegal=1 and res_wen=0, and the condition flag keeps its value.
- R9: The condition flag changes only on an input transfer of a legal instruction, and it is 0 after reset. After reset out_vld is 0.
- R10: While out_vld is 1 and out_rdy is 0, in_rdy is 0 and the output fields stay stable. When out_rdy rises, a waiting instruction is accepted in the same cycle as the drain.
- R11: An accepted legal instruction produces out_vld=1, res_wen=1 and res_illegal=0 one cycle after the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Instruction and operands are valid |
| in_rdy | output | 1 | Block can take an instruction this cycle |
| in_instr | input | 32 | Instruction word |
| in_src0 | input | 32 | First operand value |
| in_src1 | input | 32 | Second operand value |
| out_vld | output | 1 | Output beat is valid |
| out_rdy | input | 1 | Consumer takes the output beat |
| res_data | output | 32 | Computed result |
| res_dst | output | 7 | Destination register index |
| res_wen | output | 1 | Destination write-enable |
| res_illegal | output | 1 | Instruction encoding was illegal |
| cond_flag | output | 1 | Current condition flag |

## Verification
Two functions can meet in one clock edge. The first is draining a stalled output beat. The second is accepting a new instruction, whose flag update depends on the flag left by the stalled one.

The bench provokes this case as follows:

1. It holds out_rdy low after one add.
2. It presents a second add that would set the flag, and checks that the result, the destination and the flag all stay frozen.
3. It raises out_rdy while the second add is still offered.
4. On the next sample it expects the second result, its destination and its flag value together.

The chained carry and borrow rows also judge the flag written by one instruction and consumed by the next on back-to-back transfers.

// File: rtl/salu_pkg.sv
package salu_pkg;

  localparam int INSTR_W = 32;
  localparam int SEL_W   = 8;
  localparam int DST_W   = 7;
  localparam int OPC_W   = 7;
  localparam int TAG_W   = 2;
  localparam logic [TAG_W-1:0] TAG_LEGAL = 2'b10;
  localparam int NUM_OPS = 8;

  typedef enum logic [2:0] {
    OP_ADD_U = 3'd0,
    OP_SUB_U = 3'd1,
    OP_ADD_S = 3'd2,
    OP_SUB_S = 3'd3,
    OP_ADD_C = 3'd4,
    OP_SUB_B = 3'd5,
    OP_MIN_S = 3'd6,
    OP_MIN_U = 3'd7
  } salu_op_e;

  // Field order is fixed by the format: MSB first.
  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [OPC_W-1:0] opc;
    logic [DST_W-1:0] dst;
    logic [SEL_W-1:0] sel1;
    logic [SEL_W-1:0] sel0;
  } salu_instr_t;

endpackage

// File: rtl/salu_decode.sv
module salu_decode
  import salu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output salu_op_e           op,
  output logic [DST_W-1:0]   dst,
  output logic               legal
);

  salu_instr_t fields;
  logic        tag_ok;
  logic        opc_ok;

  always_comb begin
    fields = salu_instr_t'(instr);
    tag_ok = (fields.tag == TAG_LEGAL);
    opc_ok = (fields.opc < OPC_W'(NUM_OPS));
    legal  = tag_ok && opc_ok;
    op     = salu_op_e'(fields.opc[2:0]);
    dst    = fields.dst;
  end

endmodule

// File: rtl/salu_exec.sv
module salu_exec
  import salu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  salu_op_e            op,
  input  logic [DATA_W-1:0]   src0,
  input  logic [DATA_W-1:0]   src1,
  input  logic                flag_in,
  output logic [DATA_W-1:0]   result,
  output logic                flag_out
);

  localparam int MSB = DATA_W - 1;
  localparam int EXT = DATA_W + 1;

  logic           carry_in;
  logic           borrow_in;
  logic [EXT-1:0] sum_ext;
  logic [EXT-1:0] dif_ext;
  logic           ovf_add;
  logic           ovf_sub;
  logic           lt_uns;
  logic           lt_sgn;

  always_comb begin
    carry_in  = (op == OP_ADD_C) && flag_in;
    borrow_in = (op == OP_SUB_B) && flag_in;
    sum_ext   = {1'b0, src0} + {1'b0, src1} + EXT'(carry_in);
    dif_ext   = {1'b0, src0} - {1'b0, src1} - EXT'(borrow_in);
    ovf_add   = (src0[MSB] == src1[MSB]) && (sum_ext[MSB] != src0[MSB]);
    ovf_sub   = (src0[MSB] != src1[MSB]) && (dif_ext[MSB] != src0[MSB]);
    lt_uns    = src0 < src1;
    lt_sgn    = $signed(src0) < $signed(src1);
  end

  always_comb begin
    result   = '0;
    flag_out = flag_in;
    unique case (op)
      OP_ADD_U, OP_ADD_C: begin
        result   = sum_ext[DATA_W-1:0];
        flag_out = sum_ext[DATA_W];
      end
      OP_SUB_U, OP_SUB_B: begin
        result   = dif_ext[DATA_W-1:0];
        flag_out = dif_ext[DATA_W];
      end
      OP_ADD_S: begin
        result   = sum_ext[DATA_W-1:0];
        flag_out = ovf_add;
      end
      OP_SUB_S: begin
        result   = dif_ext[DATA_W-1:0];
        flag_out = ovf_sub;
      end
      OP_MIN_S: begin
        result   = lt_sgn ? src0 : src1;
        flag_out = lt_sgn;
      end
      OP_MIN_U: begin
        result   = lt_uns ? src0 : src1;
        flag_out = lt_uns;
      end
      default: begin
        result   = '0;
        flag_out = flag_in;
      end
    endcase
  end

endmodule

// File: rtl/salu_outstage.sv
module salu_outstage #(
  parameter int DATA_W = 32,
  parameter int DST_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] nxt_data,
  input  logic [DST_W-1:0]  nxt_dst,
  input  logic              nxt_legal,
  input  logic              drain_rdy,
  output logic              stage_rdy,
  output logic              q_vld,
  output logic [DATA_W-1:0] q_data,
  output logic [DST_W-1:0]  q_dst,
  output logic              q_wen,
  output logic              q_illegal
);

  assign stage_rdy = !q_vld || drain_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld     <= 1'b0;
      q_data    <= '0;
      q_dst     <= '0;
      q_wen     <= 1'b0;
      q_illegal <= 1'b0;
    end else if (stage_rdy) begin
      q_vld <= take;
      if (take) begin
        q_data    <= nxt_legal ? nxt_data : '0;
        q_dst     <= nxt_dst;
        q_wen     <= nxt_legal;
        q_illegal <= !nxt_legal;
      end
    end
  end

endmodule

// File: rtl/scalar_alu_flag.sv
module scalar_alu_flag
  import salu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  output logic                in_rdy,
  input  logic [INSTR_W-1:0]  in_instr,
  input  logic [DATA_W-1:0]   in_src0,
  input  logic [DATA_W-1:0]   in_src1,
  output logic                out_vld,
  input  logic                out_rdy,
  output logic [DATA_W-1:0]   res_data,
  output logic [DST_W-1:0]    res_dst,
  output logic                res_wen,
  output logic                res_illegal,
  output logic                cond_flag
);

  salu_op_e          dec_op;
  logic [DST_W-1:0]  dec_dst;
  logic              dec_legal;
  logic [DATA_W-1:0] exe_res;
  logic              exe_flag;
  logic              take;
  logic              flag_q;

  salu_decode u_dec (
    .instr (in_instr),
    .op    (dec_op),
    .dst   (dec_dst),
    .legal (dec_legal)
  );

  salu_exec #(.DATA_W(DATA_W)) u_exe (
    .op       (dec_op),
    .src0     (in_src0),
    .src1     (in_src1),
    .flag_in  (flag_q),
    .result   (exe_res),
    .flag_out (exe_flag)
  );

  assign take = in_vld && in_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag_q <= 1'b0;
    else if (take && dec_legal) flag_q <= exe_flag;
  end

  salu_outstage #(.DATA_W(DATA_W), .DST_W(DST_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .nxt_data  (exe_res),
    .nxt_dst   (dec_dst),
    .nxt_legal (dec_legal),
    .drain_rdy (out_rdy),
    .stage_rdy (in_rdy),
    .q_vld     (out_vld),
    .q_data    (res_data),
    .q_dst     (res_dst),
    .q_wen     (res_wen),
    .q_illegal (res_illegal)
  );

  assign cond_flag = flag_q;

endmodule

// File: rtl/salu_chk.sv
module salu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic              in_rdy,
  input logic [31:0]       in_instr,
  input logic [DATA_W-1:0] in_src0,
  input logic [DATA_W-1:0] in_src1,
  input logic              out_vld,
  input logic              out_rdy,
  input logic [DATA_W-1:0] res_data,
  input logic [6:0]        res_dst,
  input logic              res_wen,
  input logic              res_illegal,
  input logic              cond_flag
);

  logic          xfer;
  logic          ok_enc;
  logic [DATA_W:0] ref_sum;

  assign xfer    = in_vld && in_rdy;
  assign ok_enc  = (in_instr[31:30] == 2'b10) && (in_instr[29:23] < 7'd8);
  assign ref_sum = {1'b0, in_src0} + {1'b0, in_src1};

  assert_flag_only_on_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> cond_flag == $past(cond_flag));

  assert_illegal_keeps_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !ok_enc) |=> (cond_flag == $past(cond_flag)) && res_illegal && !res_wen);

  assert_stall_blocks_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy) |-> !in_rdy);

  assert_stall_holds_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy) |=> out_vld && $stable(res_data) && $stable(res_dst)
                              && $stable(res_wen) && $stable(res_illegal));

  assert_beat_after_xfer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && ok_enc) |=> out_vld && res_wen && !res_illegal);

  assert_dst_passed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> res_dst == $past(in_instr[22:16]));

  assert_add_unsigned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && ok_enc && in_instr[25:23] == 3'd0) |=>
      (res_data == $past(ref_sum[DATA_W-1:0])) && (cond_flag == $past(ref_sum[DATA_W])));

  assert_min_unsigned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && ok_enc && in_instr[25:23] == 3'd7) |=>
      cond_flag == $past(in_src0 < in_src1));

  assert_write_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> !(res_wen && res_illegal));

endmodule

bind scalar_alu_flag salu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_vld      (in_vld),
  .in_rdy      (in_rdy),
  .in_instr    (in_instr),
  .in_src0     (in_src0),
  .in_src1     (in_src1),
  .out_vld     (out_vld),
  .out_rdy     (out_rdy),
  .res_data    (res_data),
  .res_dst     (res_dst),
  .res_wen     (res_wen),
  .res_illegal (res_illegal),
  .cond_flag   (cond_flag)
);

// File: tb/scalar_alu_flag_test.sv
module scalar_alu_flag_test;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] r;
    logic        f;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 32'hFFFFFFFF, 32'h00000002, 32'h00000001, 1'b1},
    '{3'd4, 32'h00000005, 32'h00000003, 32'h00000009, 1'b0},
    '{3'd4, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF, 1'b0},
    '{3'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0},
    '{3'd2, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1},
    '{3'd2, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0},
    '{3'd1, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 1'b1},
    '{3'd5, 32'h00000010, 32'h00000004, 32'h0000000B, 1'b0},
    '{3'd1, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b1},
    '{3'd5, 32'h00000005, 32'h00000005, 32'hFFFFFFFF, 1'b1},
    '{3'd5, 32'h00000006, 32'h00000002, 32'h00000003, 1'b0},
    '{3'd3, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1},
    '{3'd3, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 1'b0},
    '{3'd6, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 1'b1},
    '{3'd7, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0},
    '{3'd6, 32'h00000003, 32'h00000003, 32'h00000003, 1'b0},
    '{3'd7, 32'h00000002, 32'h00000009, 32'h00000002, 1'b1},
    '{3'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1},
    '{3'd1, 32'h00000009, 32'h00000009, 32'h00000000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic        in_rdy;
  logic [31:0] in_instr = '0;
  logic [31:0] in_src0 = '0;
  logic [31:0] in_src1 = '0;
  logic        out_vld;
  logic        out_rdy = 1'b1;
  logic [31:0] res_data;
  logic [6:0]  res_dst;
  logic        res_wen;
  logic        res_illegal;
  logic        cond_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  scalar_alu_flag uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy),
    .in_instr(in_instr), .in_src0(in_src0), .in_src1(in_src1),
    .out_vld(out_vld), .out_rdy(out_rdy), .res_data(res_data),
    .res_dst(res_dst), .res_wen(res_wen), .res_illegal(res_illegal),
    .cond_flag(cond_flag)
  );

  function automatic logic [31:0] mk(input logic [1:0] tag, input logic [6:0] opc,
                                     input logic [6:0] dst);
    return {tag, opc, dst, 8'h21, 8'h12};
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0:       return "R2";
      3'd1:       return "R3";
      3'd2, 3'd3: return "R4";
      3'd4:       return "R5";
      3'd5:       return "R6";
      default:    return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_vld = 1'b1; in_instr = ins; in_src0 = a; in_src1 = b;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "out_vld after reset", 32'(out_vld), 32'd0);
    chk("R9", "flag after reset", 32'(cond_flag), 32'd0);
    chk("R10", "in_rdy when empty", 32'(in_rdy), 32'd1);
    rst_n = 1'b1;

    // Vector table: flag chains from row to row
    for (int i = 0; i < NV; i++) begin
      issue(mk(2'b10, {4'b0, VECS[i].op}, 7'(i + 40)), VECS[i].a, VECS[i].b);
      chk(tag_of(VECS[i].op), "result", res_data, VECS[i].r);
      chk(tag_of(VECS[i].op), "flag", 32'(cond_flag), 32'(VECS[i].f));
      chk("R1", "dst index", 32'(res_dst), 32'(i + 40));
      chk("R11", "wen/illegal", {30'd0, res_wen, res_illegal}, 32'b10);
    end

    // R10: stall, then drain and accept in one edge
    @(negedge clk);
    out_rdy = 1'b0;
    in_vld = 1'b1; in_instr = mk(2'b10, 7'd0, 7'd5); in_src0 = 32'd1; in_src1 = 32'd2;
    @(negedge clk);
    in_instr = mk(2'b10, 7'd0, 7'd6); in_src0 = 32'hFFFFFFFF; in_src1 = 32'd1;
    chk("R10", "first beat valid", 32'(out_vld), 32'd1);
    chk("R10", "in_rdy while stalled", 32'(in_rdy), 32'd0);
    chk("R2", "first beat result", res_data, 32'd3);
    @(negedge clk);
    chk("R10", "result held", res_data, 32'd3);
    chk("R10", "dst held", 32'(res_dst), 32'd5);
    chk("R9", "flag untouched during stall", 32'(cond_flag), 32'd0);
    out_rdy = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    chk("R10", "second result after drain", res_data, 32'd0);
    chk("R10", "second dst", 32'(res_dst), 32'd6);
    chk("R2", "second flag", 32'(cond_flag), 32'd1);

    // R8: bad format tag, flag currently 1
    issue(mk(2'b01, 7'd1, 7'd9), 32'd0, 32'd0);
    chk("R8", "illegal on bad tag", 32'(res_illegal), 32'd1);
    chk("R8", "no write on bad tag", 32'(res_wen), 32'd0);
    chk("R8", "flag kept on bad tag", 32'(cond_flag), 32'd1);
    // R8: opcode out of range
    issue(mk(2'b10, 7'd8, 7'd10), 32'd0, 32'd0);
    chk("R8", "illegal on opcode 8", 32'(res_illegal), 32'd1);
    chk("R8", "no write on opcode 8", 32'(res_wen), 32'd0);
    chk("R8", "flag kept on opcode 8", 32'(cond_flag), 32'd1);
    // R11: legal afterwards clears flag
    issue(mk(2'b10, 7'd1, 7'd11), 32'd0, 32'd0);
    chk("R11", "legal after illegal", {30'd0, res_wen, res_illegal}, 32'b10);
    chk("R3", "no borrow 0-0", 32'(cond_flag), 32'd0);

    // R9: idle cycles do not move the flag
    repeat (3) @(negedge clk);
    chk("R9", "out_vld clears when idle", 32'(out_vld), 32'd0);
    chk("R9", "flag stable idle", 32'(cond_flag), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule